// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block sits between ten interrupt request lines and a CPU. Each line has a one-bit priority select. The select picks between two levels, and which two depends on the line. The block looks at all pending lines, chooses one winner, and presents its vector address to the CPU together with a request strobe. The request strobe is raised only when the winner would pre-empt the service routine that is currently running.

When the CPU accepts an interrupt it pulses an acknowledge. The block then records the level of the winner on a small stack of in-service levels. A return strobe at the end of the service routine removes the most recent entry. In this way the block handles nested service: a request of equal or lower level waits, and a request of strictly higher level interrupts the current routine. A master enable masks the request strobe. It does not touch the in-service record.

Top module: `irq_vec_arbiter`

## Requirements
- R1: After reset, `irq_o` is 0 and `svc_level_o` is 0, which means nothing is in service.
- R2: Level encoding is 0 none, 1 low, 2 high, 3 highest. Lines 0 and 1 map to level 3 when their select bit is 1 and to level 1 when it is 0. Lines 2 to 9 map to level 2 when their select bit is 1 and to level 1 when it is 0.
- R3: When several lines are pending at different levels, the line with the highest level wins.
- R4: When several pending lines share the top level, the line with the lowest index wins.
- R5: `vec_addr_o` equals 8'h03 + 8 × (winner index), so line 0 gives 03h and line 9 gives 4Bh.
- R6: `irq_o` is 1 only when the winner's level is strictly greater than `svc_level_o`. A request of equal or lower level is refused.
- R7: An `ack_i` in a cycle where `irq_o` is 1 and `ret_i` is 0 pushes the winner's level. From the next cycle that level appears on `svc_level_o`.
- R8: A `ret_i` pops the newest in-service level, and `svc_level_o` falls back to the one below it. A `ret_i` with nothing in service has no effect.
- R9: With `en_i` at 0, `irq_o` is 0. Returns still pop the in-service record while `en_i` is low.
- R10: An `ack_i` while `irq_o` is 0 leaves `svc_level_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 10 | Interrupt request lines, level sensitive |
| sel_i | input | 10 | Per-line priority select bit |
| en_i | input | 1 | Master enable for the request to the CPU |
| ack_i | input | 1 | CPU accepts the presented interrupt |
| ret_i | input | 1 | CPU returns from the current service routine |
| irq_o | output | 1 | Request to the CPU |
| vec_addr_o | output | 8 | Vector address of the current winner |
| svc_level_o | output | 2 | Level at the top of the in-service record |

## Verification
The assertions assume that `ack_i` and `ret_i` are single-cycle pulses and that the two are never raised in the same cycle. They also assume that the request and select inputs change only between clock edges. The bench drives every input on the falling edge. It pulses `ack_i` and `ret_i` one at a time, and it never combines them. Because nesting requires levels that rise strictly, the stimulus never needs more than three in-service entries, and it keeps to that depth.

// File: rtl/irq_arb_pkg.sv
// Shared level type and encodings for the interrupt arbiter.
// Assumes a larger numeric value always means a more urgent level.
package irq_arb_pkg;
    typedef logic [1:0] lvl_t;
    localparam lvl_t LVL_NONE = 2'd0;
    localparam lvl_t LVL_LOW  = 2'd1;
    localparam lvl_t LVL_HIGH = 2'd2;
    localparam lvl_t LVL_TOP  = 2'd3;
endpackage

// File: rtl/irq_prio_map.sv
// Maps each request line and its select bit onto a priority level.
// The first NUM_TOP lines choose between top and low levels.
// The remaining lines choose between high and low levels.
// An idle line maps to LVL_NONE.
module irq_prio_map
    import irq_arb_pkg::*;
#(
    parameter int NUM_VEC = 10,
    parameter int NUM_TOP = 2
) (
    input  logic [NUM_VEC-1:0]      req_i,
    input  logic [NUM_VEC-1:0]      sel_i,
    output lvl_t [NUM_VEC-1:0]      lvl_o
);
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_line
        if (g < NUM_TOP) begin : g_top
            // top-capable line: select chooses top or low
            assign lvl_o[g] = !req_i[g] ? LVL_NONE : (sel_i[g] ? LVL_TOP : LVL_LOW);
        end else begin : g_std
            // standard line: select chooses high or low
            assign lvl_o[g] = !req_i[g] ? LVL_NONE : (sel_i[g] ? LVL_HIGH : LVL_LOW);
        end
    end
endmodule

// File: rtl/irq_winner_pick.sv
// Picks the pending line with the greatest level.
// Ties go to the lowest index.
// Purely combinational. Assumes that LVL_NONE marks an idle line.
module irq_winner_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_VEC = 10,
    localparam int IDX_W = $clog2(NUM_VEC)
) (
    input  lvl_t [NUM_VEC-1:0]  lvl_i,
    output logic                found_o,
    output logic [IDX_W-1:0]    idx_o,
    output lvl_t                lvl_o
);
    // scan from the top index down so that a lower index replaces an equal level
    always_comb begin
        lvl_o = LVL_NONE;
        idx_o = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (lvl_i[i] != LVL_NONE && lvl_i[i] >= lvl_o) begin
                lvl_o = lvl_i[i];
                idx_o = IDX_W'(i);
            end
        end
        found_o = (lvl_o != LVL_NONE);
    end
endmodule

// File: rtl/irq_level_stack.sv
// LIFO record of the levels in service.
// Pop takes priority over push.
// A push when full and a pop when empty are both dropped.
// top_o reads LVL_NONE while the record is empty.
module irq_level_stack
    import irq_arb_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  lvl_t push_lvl_i,
    input  logic pop_i,
    output lvl_t top_o
);
    lvl_t             stk_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;

    // keep the occupancy count and write pushed levels into the slot above the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= LVL_NONE;
        end else if (pop_i) begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end else if (push_i && cnt_q != CNT_W'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++)
                if (CNT_W'(i) == cnt_q) stk_q[i] <= push_lvl_i;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // report the newest occupied slot
    always_comb begin
        top_o = LVL_NONE;
        for (int i = 0; i < DEPTH; i++)
            if (CNT_W'(i) < cnt_q) top_o = stk_q[i];
    end
endmodule

// File: rtl/irq_vec_arbiter.sv
// Top level of the vectored interrupt arbiter.
// It maps the lines to levels, picks a winner and compares the winner with the level in service.
// An accepted acknowledge pushes the winner's level, and a return pops it.
// Assumes that ack_i and ret_i are single-cycle pulses from the CPU.
module irq_vec_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_VEC  = 10,
    parameter int NUM_TOP  = 2,
    parameter int DEPTH    = 3,
    parameter int ADDR_W   = 8,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8,
    localparam int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_VEC-1:0]  req_i,
    input  logic [NUM_VEC-1:0]  sel_i,
    input  logic                en_i,
    input  logic                ack_i,
    input  logic                ret_i,
    output logic                irq_o,
    output logic [ADDR_W-1:0]   vec_addr_o,
    output logic [1:0]          svc_level_o
);
    lvl_t [NUM_VEC-1:0] line_lvl;
    logic               win_found;
    logic [IDX_W-1:0]   win_idx;
    lvl_t               win_lvl;
    lvl_t               svc_lvl;
    logic               do_push;

    irq_prio_map #(.NUM_VEC(NUM_VEC), .NUM_TOP(NUM_TOP)) i_map (
        .req_i (req_i),
        .sel_i (sel_i),
        .lvl_o (line_lvl)
    );

    irq_winner_pick #(.NUM_VEC(NUM_VEC)) i_pick (
        .lvl_i   (line_lvl),
        .found_o (win_found),
        .idx_o   (win_idx),
        .lvl_o   (win_lvl)
    );

    irq_level_stack #(.DEPTH(DEPTH)) i_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (do_push),
        .push_lvl_i (win_lvl),
        .pop_i      (ret_i),
        .top_o      (svc_lvl)
    );

    // present the winner only when it strictly outranks the service level
    always_comb begin
        irq_o       = en_i && win_found && (win_lvl > svc_lvl);
        do_push     = ack_i && irq_o && !ret_i;
        vec_addr_o  = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(win_idx);
        svc_level_o = svc_lvl;
    end
endmodule

// File: rtl/irq_vec_arbiter_chk.sv
// Property checker for irq_vec_arbiter, attached with bind.
// Assumes that ack_i and ret_i never pulse in the same cycle.
module irq_vec_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [9:0] req_i,
    input logic       en_i,
    input logic       ack_i,
    input logic       ret_i,
    input logic       irq_o,
    input logic [7:0] vec_addr_o,
    input logic [1:0] svc_level_o
);
    // R9
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !irq_o);
    // R6
    irq_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (req_i != '0 && svc_level_o != 2'd3));
    // R5
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> vec_addr_o[2:0] == 3'd3 && vec_addr_o <= 8'h4B);
    // R7
    push_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !ret_i) |=> svc_level_o > $past(svc_level_o));
    // R8
    pop_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && svc_level_o != 2'd0) |=> svc_level_o < $past(svc_level_o));
    // R8
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && svc_level_o == 2'd0) |=> svc_level_o == 2'd0);
    // R10
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !ret_i) |=> $stable(svc_level_o));
endmodule

bind irq_vec_arbiter irq_vec_arbiter_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .en_i        (en_i),
    .ack_i       (ack_i),
    .ret_i       (ret_i),
    .irq_o       (irq_o),
    .vec_addr_o  (vec_addr_o),
    .svc_level_o (svc_level_o)
);

// File: tb/test_irq_vec_arbiter.sv
module test_irq_vec_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NTBL = 10;
    // {req, sel, en, exp_irq, exp_addr}
    localparam logic [29:0] TBL [NTBL] = '{
        {10'b0000000000, 10'b0000000000, 1'b1, 1'b0, 8'h03},
        {10'b0000100000, 10'b0000000000, 1'b1, 1'b1, 8'h2B},
        {10'b0010001000, 10'b0000000000, 1'b1, 1'b1, 8'h1B},
        {10'b0010001000, 10'b0010000000, 1'b1, 1'b1, 8'h3B},
        {10'b1000000010, 10'b1000000010, 1'b1, 1'b1, 8'h0B},
        {10'b0000000011, 10'b0000000011, 1'b1, 1'b1, 8'h03},
        {10'b1000000000, 10'b0000000000, 1'b0, 1'b0, 8'h4B},
        {10'b1111111111, 10'b0000000000, 1'b1, 1'b1, 8'h03},
        {10'b0100000100, 10'b0100000000, 1'b1, 1'b1, 8'h43},
        {10'b1000000000, 10'b0000000000, 1'b1, 1'b1, 8'h4B}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] req = '0, sel = '0;
    logic       en = 1'b0, ack = 1'b0, ret = 1'b0;
    logic       irq;
    logic [7:0] vaddr;
    logic [1:0] svc;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    irq_vec_arbiter i_irq_vec_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .sel_i(sel), .en_i(en),
        .ack_i(ack), .ret_i(ret), .irq_o(irq), .vec_addr_o(vaddr), .svc_level_o(svc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [9:0] r, input logic [9:0] s, input logic e);
        @(negedge clk);
        req = r; sel = s; en = e;
        #1;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0; #1;
    endtask

    task automatic pulse_ret();
        @(negedge clk); ret = 1'b1;
        @(negedge clk); ret = 1'b0; #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state, checked while reset is still applied
        check("R1 irq", {7'd0, irq}, 8'd0);
        check("R1 svc", {6'd0, svc}, 8'd0);
        rst_n = 1'b1;

        // table walk with nothing in service: R3 R4 R5 R6
        for (int k = 0; k < NTBL; k++) begin
            drive(TBL[k][29:20], TBL[k][19:10], TBL[k][9]);
            check($sformatf("R3/R4 irq row %0d", k), {7'd0, irq}, {7'd0, TBL[k][8]});
            if (TBL[k][8]) check($sformatf("R5 addr row %0d", k), vaddr, TBL[k][7:0]);
        end

        // R8 return with nothing in service has no effect
        drive('0, '0, 1'b1);
        pulse_ret();
        check("R8 empty ret", {6'd0, svc}, 8'd0);
        // R10 acknowledge with no request pending is ignored
        pulse_ack();
        check("R10 stray ack", {6'd0, svc}, 8'd0);

        // nesting L -> H -> X: R2 R6 R7
        drive(10'b0000010000, '0, 1'b1);
        pulse_ack();
        check("R7 push low", {6'd0, svc}, 8'd1);
        check("R6 equal refused", {7'd0, irq}, 8'd0);
        drive(10'b0000000100, '0, 1'b1);
        check("R6 low refused", {7'd0, irq}, 8'd0);
        drive(10'b0000000100, 10'b0000000100, 1'b1);
        check("R6 high presented", {7'd0, irq}, 8'd1);
        check("R5 addr line2", vaddr, 8'h13);
        pulse_ack();
        check("R2 line2 high", {6'd0, svc}, 8'd2);
        drive(10'b0000000001, 10'b0000000001, 1'b1);
        check("R6 top presented", {7'd0, irq}, 8'd1);
        pulse_ack();
        check("R2 line0 top", {6'd0, svc}, 8'd3);
        drive(10'b1111111111, 10'b1111111111, 1'b1);
        check("R6 all refused at top", {7'd0, irq}, 8'd0);

        // R9 enable off masks the request but returns still pop
        drive(10'b0000000001, 10'b0000000001, 1'b0);
        pulse_ret();
        check("R9 pop with en low", {6'd0, svc}, 8'd2);
        check("R9 irq masked", {7'd0, irq}, 8'd0);
        pulse_ret();
        check("R8 pop to low", {6'd0, svc}, 8'd1);
        pulse_ret();
        check("R8 pop to empty", {6'd0, svc}, 8'd0);

        // R2 line 1 with select 0 is low
        drive(10'b0000000010, 10'b0000000000, 1'b1);
        pulse_ack();
        check("R2 line1 low", {6'd0, svc}, 8'd1);
        pulse_ret();
        // R2 line 5 with select 1 is high
        drive(10'b0000100000, 10'b0000100000, 1'b1);
        pulse_ack();
        check("R2 line5 high", {6'd0, svc}, 8'd2);
        pulse_ret();
        check("R8 final empty", {6'd0, svc}, 8'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule